// File: doc/BRIEF.md
# Parallel Byte-Lane CRC-32 Engine

This block computes the Ethernet CRC-32 over a packet. Each clock it can take in up to sixteen bytes from a 128-bit word. A caller presents a word with a valid strobe and a count field, and the engine folds the selected bytes into a running checksum. The byte that goes first on the wire sits in the top byte lane. The remaining bytes follow in order toward bit 0.

The word is registered first. The fold happens in the next cycle, and the updated checksum can be read one cycle after that. A seed input is raised in the fold cycle of a packet's first word. It makes that fold start from all ones instead of from the previous checksum, so packets can follow each other with no gap. Any fold cycle with no valid word also reloads the seed. The output is the finished, inverted CRC, with the first CRC byte sent on the wire in bits 7:0. Framing, handshakes, result storage and pass/fail decisions belong to the caller.

Top module: `crc32_lane_engine`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state loads all ones. From the next cycle `crc_o` reads 32'h00000000.
- R2: A word with `vld_i` high at edge N is folded during the following cycle. Its result appears on `crc_o` after edge N+1. It equals the reflected CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF, final inversion) of all bytes folded since the last seed. Byte k of a word is `data_i[127-8k -: 8]`.
- R3: Only the first `cnt_i`+1 byte lanes, counted from the top lane, are folded. Lanes below that count have no effect on `crc_o`.
- R4: A word folded while `seed_i` is low continues from the checksum left by the previous fold.
- R5: With `seed_i` high in a fold cycle, that fold starts from 0xFFFFFFFF whatever the previous state was. This lets back-to-back packets restart cleanly.
- R6: A cycle whose registered word is not valid reloads the seed. After it, `crc_o` reads 0, whatever `data_i`, `cnt_i` and `seed_i` were.
- R7: The ASCII bytes "123456789" in one word give `crc_o` = 32'hCBF43926.
- R8: A message followed by its own CRC, sent low byte first, gives `crc_o` = 32'h2144DF1C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| vld_i | input | 1 | Word on `data_i` is to be folded |
| cnt_i | input | 4 | Number of valid bytes minus one |
| data_i | input | 128 | Input word, first wire byte in bits 127:120 |
| seed_i | input | 1 | Start this cycle's fold from the seed value |
| crc_o | output | 32 | Running CRC, first wire byte in bits 7:0 |

## Verification
The seed restart and the fold of a new word fall in the same cycle whenever one packet's first word directly follows the previous packet's last word. The bench provokes this by sending packets of every length from 1 to 16 bytes, and longer multi-word packets, back to back with no idle cycle between them. Each first-word fold is judged against a serial bit-by-bit model that restarts from all ones. The idle reload can also coincide with a raised seed. That case is judged by requiring a zero result.

// File: rtl/crc32_lane_pkg.sv
package crc32_lane_pkg;

  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_NORMAL = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED        = 32'hFFFFFFFF;

  // bit-reverse a 32-bit value
  function automatic logic [CRC_W-1:0] reflect32(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] CRC_POLY_REFL = reflect32(CRC_POLY_NORMAL);

  // fold one byte into reflected state, least significant bit first
  function automatic logic [CRC_W-1:0] crc_shift_byte(input logic [CRC_W-1:0] s,
                                                      input logic [7:0] b);
    logic [CRC_W-1:0] t;
    t = s;
    for (int j = 0; j < 8; j++) begin
      if (t[0] ^ b[j]) t = (t >> 1) ^ CRC_POLY_REFL;
      else             t = t >> 1;
    end
    return t;
  endfunction

  // presented form of the state: final inversion
  function automatic logic [CRC_W-1:0] crc_present(input logic [CRC_W-1:0] s);
    return ~s;
  endfunction

endpackage

// File: rtl/crc32_in_stage.sv
module crc32_in_stage #(
  parameter int LANES = 16,
  localparam int CNT_W  = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_i;
      cnt_q  <= cnt_i;
      data_q <= data_i;
    end
  end

endmodule

// File: rtl/crc32_fold.sv
module crc32_fold #(
  parameter int LANES = 16,
  localparam int CNT_W  = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic [31:0]       state_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [31:0]       state_o
);

  logic [LANES:0][31:0] chain;
  logic [LANES-1:0]     lane_on;

  assign chain[0] = state_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_byte;
    assign lane_byte  = data_i[DATA_W-1-8*g -: 8];
    assign lane_on[g] = (cnt_i >= CNT_W'(g));
    assign chain[g+1] = lane_on[g] ? crc32_lane_pkg::crc_shift_byte(chain[g], lane_byte)
                                   : chain[g];
  end

  assign state_o = chain[LANES];

endmodule

// File: rtl/crc32_state.sv
module crc32_state (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fold_en,
  input  logic [31:0] folded,
  output logic [31:0] state_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= crc32_lane_pkg::CRC_SEED;
    else if (fold_en) state_q <= folded;
    else              state_q <= crc32_lane_pkg::CRC_SEED;
  end

endmodule

// File: rtl/crc32_lane_engine.sv
module crc32_lane_engine #(
  parameter int LANES = 16,
  localparam int CNT_W  = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              seed_i,
  output logic [31:0]       crc_o
);

  logic              fold_en;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic [31:0]       state_q;
  logic [31:0]       base_state;
  logic [31:0]       folded;

  crc32_in_stage #(.LANES(LANES)) u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (vld_i),
    .cnt_i  (cnt_i),
    .data_i (data_i),
    .vld_q  (fold_en),
    .cnt_q  (cnt_q),
    .data_q (data_q)
  );

  // seed applies in the fold cycle, unregistered
  assign base_state = seed_i ? crc32_lane_pkg::CRC_SEED : state_q;

  crc32_fold #(.LANES(LANES)) u_fold (
    .state_i (base_state),
    .data_i  (data_q),
    .cnt_i   (cnt_q),
    .state_o (folded)
  );

  crc32_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .fold_en (fold_en),
    .folded  (folded),
    .state_q (state_q)
  );

  assign crc_o = crc32_lane_pkg::crc_present(state_q);

endmodule

// File: rtl/crc32_lane_engine_chk.sv
module crc32_lane_engine_chk #(
  parameter int LANES = 16,
  localparam int CNT_W  = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vld_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] data_i,
  input logic              seed_i,
  input logic [31:0]       crc_o
);

  // serial bitstream model, one bit per step
  function automatic logic [31:0] ser_fold(input logic [31:0] s,
                                           input logic [DATA_W-1:0] d,
                                           input logic [CNT_W-1:0] c);
    logic [31:0] t;
    t = s;
    for (int i = 0; i < DATA_W; i++) begin
      if ((i / 8) <= int'(c)) begin
        if (t[0] ^ d[DATA_W-8-8*(i/8)+(i%8)]) t = (t >> 1) ^ 32'hEDB88320;
        else                                  t = t >> 1;
      end
    end
    return t;
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> crc_o == 32'h0);

  // R6
  idle_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ##1 crc_o == 32'h0);

  // R5
  seeded_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(vld_i) && seed_i)
    |=> crc_o == ~ser_fold(32'hFFFFFFFF, $past(data_i, 2), $past(cnt_i, 2)));

  // R4
  continued_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(vld_i) && !seed_i)
    |=> crc_o == ~ser_fold(~$past(crc_o), $past(data_i, 2), $past(cnt_i, 2)));

endmodule

bind crc32_lane_engine crc32_lane_engine_chk #(.LANES(LANES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .vld_i  (vld_i),
  .cnt_i  (cnt_i),
  .data_i (data_i),
  .seed_i (seed_i),
  .crc_o  (crc_o)
);

// File: tb/sim_crc32_lane_engine.sv
module sim_crc32_lane_engine;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld_i = 1'b0;
  logic [3:0]   cnt_i = '0;
  logic [127:0] data_i = '0;
  logic         seed_i = 1'b0;
  logic [31:0]  crc_o;

  crc32_lane_engine u0 (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .cnt_i(cnt_i),
    .data_i(data_i), .seed_i(seed_i), .crc_o(crc_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;

  // scoreboard queues
  int          q_due[$];
  logic [31:0] q_val[$];
  string       q_req[$];

  logic [31:0] st = 32'hFFFFFFFF;
  bit          pend_seed = 1'b0;
  logic [7:0]  pkt[$];

  function automatic logic [31:0] ref_byte(input logic [31:0] s, input logic [7:0] b);
    logic [31:0] t;
    t = s;
    for (int j = 0; j < 8; j++) begin
      logic fb;
      fb = t[0] ^ b[j];
      t = t >> 1;
      if (fb) t = t ^ 32'hEDB88320;
    end
    return t;
  endfunction

  task automatic push(input int due, input logic [31:0] v, input string req);
    q_due.push_back(due);
    q_val.push_back(v);
    q_req.push_back(req);
  endtask

  task automatic drive_word(input logic [127:0] w, input int nb, input bit first,
                            input string req);
    @(negedge clk);
    seed_i    = pend_seed;
    pend_seed = first;
    vld_i     = 1'b1;
    data_i    = w;
    cnt_i     = 4'(nb - 1);
    if (first) st = 32'hFFFFFFFF;
    for (int k = 0; k < nb; k++) st = ref_byte(st, w[127-8*k -: 8]);
    push(cyc + 2, ~st, req);
  endtask

  task automatic drive_idle(input string req);
    @(negedge clk);
    seed_i    = pend_seed;
    pend_seed = 1'b0;
    vld_i     = 1'b0;
    data_i    = {4{32'hDEADBEEF ^ 32'(cyc)}};
    cnt_i     = 4'(cyc);
    st        = 32'hFFFFFFFF;
    push(cyc + 2, 32'h0, req);
  endtask

  // sends global pkt; unused lanes get garbage
  task automatic send_pkt(input string req);
    int n;
    n = pkt.size();
    for (int base = 0; base < n; base += 16) begin
      logic [127:0] w;
      int nb;
      nb = (n - base) < 16 ? (n - base) : 16;
      for (int k = 0; k < 16; k++)
        w[127-8*k -: 8] = (k < nb) ? pkt[base+k] : 8'(8'h5A + k);
      drive_word(w, nb, base == 0, req);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      total++;
      if (crc_o !== q_val[0]) begin
        bad++;
        $display("FAIL %s actual=%08h expected=%08h cycle=%0d", q_req[0], crc_o, q_val[0], cyc);
      end
      void'(q_due.pop_front());
      void'(q_val.pop_front());
      void'(q_req.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (crc_o !== 32'h0) begin
      bad++;
      $display("FAIL R1 actual=%08h expected=%08h", crc_o, 32'h0);
    end

    // R7 check value
    pkt = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_pkt("R7");
    q_val[q_val.size()-1] = 32'hCBF43926;
    drive_idle("R6");

    // R3 / R5: every byte count, back to back, seeded on each first word
    for (int n = 1; n <= 16; n++) begin
      pkt = {};
      for (int k = 0; k < n; k++) pkt.push_back(8'((n * 7 + k) * 13));
      send_pkt(n == 16 ? "R5" : "R3");
    end
    drive_idle("R6");

    // R4: multi-word packets, back to back
    pkt = {};
    for (int k = 0; k < 40; k++) pkt.push_back(8'(k * 29 + 3));
    send_pkt("R4");
    pkt = {};
    for (int k = 0; k < 37; k++) pkt.push_back(8'(k * 11 + 100));
    send_pkt("R5");
    drive_idle("R6");

    // R8 residue
    pkt = {};
    for (int k = 0; k < 21; k++) pkt.push_back(8'(k * 53 + 7));
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 21; k++) c = ref_byte(c, pkt[k]);
    c = ~c;
    for (int k = 0; k < 4; k++) pkt.push_back(c[8*k +: 8]);
    send_pkt("R8");
    q_val[q_val.size()-1] = 32'h2144DF1C;
    drive_idle("R6");

    // R6: idle streak with noise on inputs
    repeat (3) drive_idle("R6");

    // R2: packet shorter than a word, then idle with seed pending
    pkt = {8'hA1, 8'h00, 8'hFF};
    send_pkt("R2");
    drive_idle("R6");
    drive_idle("R6");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule